// File: doc/BRIEF.md
# UART Receive Buffer

This block holds the bytes that a UART receiver delivers until software collects them over a simple register bus. It runs in one of two modes, chosen by an enable bit in its control register. In queue mode, incoming bytes enter a first-in first-out store of parameterised depth. In single-register mode, one holding register keeps only the most recent byte.

A read of the receive-data register returns the oldest byte and removes it from the store. Status registers report the fill level, a full flag and the data-ready condition. A read-to-clear error register captures overrun, parity, frame and break events. The status word also forwards the fill level and full flag of a neighbouring transmit queue. Two self-clearing control bits flush the receive store and send a one-cycle flush pulse to the transmit side.

Two one-cycle request pulses go to the interrupt logic. One marks every received byte. The other marks an error: a byte dropped because the store was full, or a read of an empty store.

Register map. Addresses are in `addr` units: 0 is control, 1 is line status, 2 is queue status, 3 is error status and 4 is receive data. All registers are read combinationally in the cycle `rd_en` is high, and side effects take place at the following clock edge.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, the control, line-status, queue-status and error-status registers all read 0, and the request outputs are low.
- R2: With control bit 0 set (queue mode), each received byte is stored. Reads of address 4 return the bytes in arrival order. Queue-status bits [7:0] give the number of stored bytes while the store is not full.
- R3: When the store holds DEPTH bytes, queue-status bit 8 is 1 and bits [7:0] read 0.
- R4: A byte that arrives while the store is full and no pop happens in the same cycle is dropped. Error bit 0 (overrun) is then set, `err_req` pulses in the next cycle, and line-status bit 0 stays 1.
- R5: A read of address 4 in queue mode while the store is empty returns 0 and pulses `err_req` in the next cycle.
- R6: Line-status bit 0 (data ready) is 1 while the store holds at least one byte. It clears after the pop that removes the last byte.
- R7: With control bit 0 clear, each received byte overwrites a single holding register and sets data ready. A read of address 4 returns the held byte and clears data ready, and later reads return the same byte.
- R8: A break event stores a zero byte as if it had been received and sets error bit 3.
- R9: A byte received with its parity flag sets error bit 1, and one received with its frame flag sets error bit 2. A read of address 3 returns the error bits and clears them afterwards.
- R10: A control write with bit 1 set empties the receive store. A control write with bit 2 set pulses `tx_flush` for one cycle. Bits 1 and 2 read back 0, while bit 0 reads back as written.
- R11: Queue-status bits [23:16] reflect `tx_count` and bit 24 reflects `tx_full`.
- R12: Every received byte or break pulses `rx_req` in the next cycle, whether or not the byte is kept.
- R13: In the same cycle, a read of address 4 and an arriving byte on a full store both take effect. The store stays full, the new byte is kept, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error flag of the delivered byte |
| rx_frm_err | input | 1 | Frame error flag of the delivered byte |
| rx_break | input | 1 | Break condition detected this cycle |
| tx_count | input | 8 | Fill level of the transmit queue |
| tx_full | input | 1 | Transmit queue full |
| wr_en | input | 1 | Bus write strobe (control register only) |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 3 | Control write data |
| rd_data | output | 32 | Register read data |
| rx_req | output | 1 | Receive request pulse |
| err_req | output | 1 | Error request pulse |
| tx_flush | output | 1 | Transmit queue flush pulse |

## Verification
The bench builds the block with DEPTH set to 4. This makes the full-store boundary, the overrun drop, the simultaneous pop-and-push on a full store, and read-pointer wraparound all reachable within a few cycles. At that depth, every fill level from empty to full is swept, both on the way up and on the way down. Expected values come from a count the bench keeps itself and from a known byte pattern. Several fill-and-drain rounds shift the pointer phase, so wrapping is covered at more than one starting offset.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LINE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FSTAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_ESTAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_RDATA = 3'd4;

  // error status bit positions
  localparam int unsigned E_OVR = 0;
  localparam int unsigned E_PAR = 1;
  localparam int unsigned E_FRM = 2;
  localparam int unsigned E_BRK = 3;
  localparam int unsigned E_W   = 4;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && (!full || pop_ok) && !flush;
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = bump(wp_q);
      if (pop_ok)  rp_d = bump(rp_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R13
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && push && !flush) |=> full);
endmodule

// File: rtl/rxb_errstat.sv
module rxb_errstat #(
  parameter int unsigned EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set_vec,
  input  logic          rd_clr,
  output logic [EW-1:0] bits
);
  logic [EW-1:0] q, d;

  always_comb begin
    d = (rd_clr ? '0 : q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign bits = q;

  // R9
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (bits == '0));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_break,
  input  logic [7:0]        tx_count,
  input  logic              tx_full,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        wr_data,
  output logic [31:0]       rd_data,
  output logic              rx_req,
  output logic              err_req,
  output logic              tx_flush
);
  logic          qmode_q, qmode_d;
  logic [7:0]    hold_q, hold_d;
  logic          hv_q, hv_d;
  logic          rxr_q, errr_q, txf_q;
  logic          ctrl_wr, rx_flush, tx_flush_d;
  logic          in_evt, rd_rx, pop_req, underflow, overrun;
  logic [7:0]    in_byte, head;
  logic [CW-1:0] count;
  logic          full, empty, ready;
  logic [E_W-1:0] err_set, err_bits;

  assign ctrl_wr    = wr_en && (addr == A_CTRL);
  assign rx_flush   = ctrl_wr && wr_data[1];
  assign tx_flush_d = ctrl_wr && wr_data[2];

  assign in_evt  = rx_valid || rx_break;
  assign in_byte = rx_break ? 8'h00 : rx_data;
  assign rd_rx   = rd_en && (addr == A_RDATA);
  assign pop_req = rd_rx && qmode_q;

  assign underflow = pop_req && empty;
  assign overrun   = in_evt && qmode_q && !rx_flush && full && !pop_req;

  assign err_set[E_OVR] = overrun;
  assign err_set[E_PAR] = rx_valid && rx_par_err;
  assign err_set[E_FRM] = rx_valid && rx_frm_err;
  assign err_set[E_BRK] = rx_break;

  rxb_store #(.DEPTH(DEPTH), .DW(8)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (in_evt && qmode_q),
    .pop   (pop_req),
    .din   (in_byte),
    .head  (head),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rxb_errstat #(.EW(E_W)) i_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .rd_clr  (rd_en && (addr == A_ESTAT)),
    .bits    (err_bits)
  );

  always_comb begin
    qmode_d = qmode_q;
    hold_d  = hold_q;
    hv_d    = hv_q;
    if (ctrl_wr) qmode_d = wr_data[0];
    if (in_evt && !qmode_q) begin
      hold_d = in_byte;
      hv_d   = 1'b1;
    end else if (rd_rx && !qmode_q) begin
      hv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qmode_q <= 1'b0;
      hold_q  <= 8'h00;
      hv_q    <= 1'b0;
      rxr_q   <= 1'b0;
      errr_q  <= 1'b0;
      txf_q   <= 1'b0;
    end else begin
      qmode_q <= qmode_d;
      hold_q  <= hold_d;
      hv_q    <= hv_d;
      rxr_q   <= in_evt;
      errr_q  <= overrun || underflow;
      txf_q   <= tx_flush_d;
    end
  end

  assign ready = qmode_q ? !empty : hv_q;

  always_comb begin
    rd_data = 32'h0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rd_data = {31'h0, qmode_q};
        A_LINE:  rd_data = {31'h0, ready};
        A_FSTAT: rd_data = {7'h0, tx_full, tx_count, 7'h0, full,
                            full ? 8'h00 : 8'(count)};
        A_ESTAT: rd_data = {{(32-E_W){1'b0}}, err_bits};
        A_RDATA: rd_data = {24'h0, qmode_q ? (empty ? 8'h00 : head) : hold_q};
        default: rd_data = 32'h0;
      endcase
    end
  end

  assign rx_req   = rxr_q;
  assign err_req  = errr_q;
  assign tx_flush = txf_q;

  // R5
  underflow_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> err_req);

  // R4
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_evt && qmode_q && full && !pop_req && !rx_flush) |=> (full && err_req));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (count == '0));

  // R6
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == CW'(1) && !in_evt && !ctrl_wr) |=> !ready);

  // R12
  rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_evt |=> rx_req);
endmodule

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = 8'h00, tx_count = 8'h00;
  logic        tx_full = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0, wr_data = 3'd0;
  logic [31:0] rd_data;
  logic        rx_req, err_req, tx_flush;

  int n_run = 0, n_fail = 0;
  logic        last_err, last_rxq, last_txf;
  logic [31:0] v;

  always #4 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH)) i_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
    .tx_count(tx_count), .tx_full(tx_full), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rx_req(rx_req),
    .err_req(err_req), .tx_flush(tx_flush));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1;
    last_err = err_req; last_rxq = rx_req; last_txf = tx_flush;
    rx_valid = 0; rx_break = 0; rx_par_err = 0; rx_frm_err = 0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] val);
    @(negedge clk); rd_en = 1; addr = a; #1 val = rd_data;
    finish_cycle();
  endtask

  task automatic rx(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_par_err = pe; rx_frm_err = fe;
    finish_cycle();
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1;
    finish_cycle();
  endtask

  task automatic wr_ctrl(input logic [2:0] d);
    @(negedge clk); wr_en = 1; addr = 3'd0; wr_data = d;
    finish_cycle();
  endtask

  function automatic logic [31:0] fst(input int n);
    return (n >= DEPTH) ? 32'h100 : 32'(n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 line", v, 0);
    rd(3'd2, v); chk("R1 fstat", v, 0);
    rd(3'd3, v); chk("R1 estat", v, 0);
    chk("R1 req", {30'h0, rx_req, err_req}, 0);

    wr_ctrl(3'b001);
    rd(3'd0, v); chk("R10 ctrl bit0", v, 1);

    // R2 R3 R12: fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      rx(8'h10 + 8'(k), 0, 0);
      chk("R12 rx_req", {31'h0, last_rxq}, 1);
      rd(3'd2, v); chk("R2/R3 fill", v, fst(k));
    end
    // R4 overrun
    rx(8'hEE, 0, 0);
    chk("R4 err_req", {31'h0, last_err}, 1);
    chk("R12 rx_req on drop", {31'h0, last_rxq}, 1);
    rd(3'd2, v); chk("R4 still full", v, 32'h100);
    rd(3'd1, v); chk("R4 ready", v, 1);
    rd(3'd3, v); chk("R9 overrun bit", v, 1);
    rd(3'd3, v); chk("R9 cleared", v, 0);
    // R2 R6 drain sweep
    for (int k = 1; k <= DEPTH; k++) begin
      rd(3'd4, v); chk("R2 order", v, 32'h10 + 32'(k));
      rd(3'd2, v); chk("R2 drain fill", v, fst(DEPTH - k));
      rd(3'd1, v); chk("R6 ready", v, (k < DEPTH) ? 1 : 0);
    end
    // R5
    rd(3'd4, v); chk("R5 empty data", v, 0);
    chk("R5 err_req", {31'h0, last_err}, 1);

    // R2 wrap rounds at several pointer phases
    for (int r = 0; r < 3; r++) begin
      for (int j = 0; j < 3; j++) rx(8'(8'h40 + r * 8 + j), 0, 0);
      for (int j = 0; j < 3; j++) begin
        rd(3'd4, v); chk("R2 wrap order", v, 32'(8'h40 + r * 8 + j));
      end
    end

    // R13
    for (int k = 0; k < DEPTH; k++) rx(8'h80 + 8'(k), 0, 0);
    @(negedge clk); rd_en = 1; addr = 3'd4; rx_valid = 1; rx_data = 8'h55;
    #1 v = rd_data;
    finish_cycle();
    chk("R13 head", v, 32'h80);
    chk("R13 no err", {31'h0, last_err}, 0);
    rd(3'd2, v); chk("R13 full", v, 32'h100);
    rd(3'd3, v); chk("R13 no overrun", v, 0);
    for (int k = 1; k < DEPTH; k++) begin
      rd(3'd4, v); chk("R13 order", v, 32'h80 + 32'(k));
    end
    rd(3'd4, v); chk("R13 new byte", v, 32'h55);

    // R8
    brk();
    rd(3'd2, v); chk("R8 stored", v, 1);
    rd(3'd3, v); chk("R8 break bit", v, 8);
    rd(3'd4, v); chk("R8 zero byte", v, 0);
    chk("R8 no underflow", {31'h0, last_err}, 0);

    // R9
    rx(8'h21, 1, 0);
    rd(3'd3, v); chk("R9 parity", v, 2);
    rx(8'h22, 0, 1);
    rd(3'd3, v); chk("R9 frame", v, 4);
    rd(3'd3, v); chk("R9 clear", v, 0);

    // R10 flush
    rd(3'd2, v); chk("R10 pre flush", v, 2);
    wr_ctrl(3'b011);
    rd(3'd2, v); chk("R10 flushed", v, 0);
    rd(3'd1, v); chk("R10 ready low", v, 0);
    rd(3'd0, v); chk("R10 self clear", v, 1);
    chk("R10 no txflush", {31'h0, last_txf}, 0);
    wr_ctrl(3'b101);
    chk("R10 txflush", {31'h0, last_txf}, 1);
    rd(3'd0, v); chk("R10 bit2 clear", v, 1);

    // R11
    tx_count = 8'h2A; tx_full = 1;
    rd(3'd2, v); chk("R11 tx fields", v, 32'h012A0000);
    tx_count = 8'h00; tx_full = 0;

    // R7
    wr_ctrl(3'b000);
    rx(8'h61, 0, 0);
    rx(8'h62, 0, 0);
    rd(3'd1, v); chk("R7 ready", v, 1);
    rd(3'd2, v); chk("R7 fifo untouched", v, 0);
    rd(3'd4, v); chk("R7 last byte", v, 32'h62);
    rd(3'd1, v); chk("R7 ready cleared", v, 0);
    rd(3'd4, v); chk("R7 held", v, 32'h62);
    chk("R7 no err", {31'h0, last_err}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule